// File: doc/BRIEF.md
# Minifloat Nibble Quantizer

This block converts between ordinary floating-point bit patterns and a compact 4-bit code. The code keeps the sign in its top bit and a 3-bit exponent in the low three bits, and it stores no mantissa. One clocked pipeline stage runs in both directions. In encode mode the block reads a 32-bit or 16-bit floating-point operand and returns its 4-bit code. The exponent is mapped through a fixed threshold, rounded up using the most significant mantissa bit, and clamped to the largest code. In decode mode a 3-bit position selects one nibble out of a 32-bit packed word, and the block rebuilds a floating-point pattern from that nibble. The rebuilt pattern has a zero mantissa, and exponent code 0 stands for an exact zero.

Two select inputs are sampled together with `in_valid`: `op` chooses encode or decode, and `fmt` chooses single or half precision. The result appears on `dout` one clock later, with `out_valid` set. Infinities, NaNs and subnormal inputs get no special handling; they pass through the same threshold arithmetic as every other value.

Top module: `fp4q_top`

## Requirements
- R1: Encode, single precision (`op`=0, `fmt`=0). Let E be `din[30:23]` and M be `din[22]`. The code exponent is min(E-120+M, 7) when E>120, 1 when E equals 120, and 0 when E is below 120. Mantissa bits 21:0 have no effect.
- R2: Encode, half precision (`op`=0, `fmt`=1). Let E be `din[14:10]` and M be `din[9]`. The code exponent is min(E-8+M, 7) when E>8, 1 when E equals 8, and 0 otherwise. Bits 31:16 of `din` are ignored.
- R3: The code exponent saturates at 7 whenever the rounded exponent difference would be larger than 7. An exponent difference of exactly 7 also gives 7.
- R4: In encode mode, `dout[3]` carries the input sign, `dout[2:0]` carries the code exponent, and `dout[31:4]` is zero.
- R5: Decode, single precision (`op`=1, `fmt`=0), with a nonzero code exponent C. `dout[31]` is the code sign, `dout[30:23]` is C ORed with 120, and `dout[22:0]` is zero.
- R6: Decode, half precision (`op`=1, `fmt`=1), with a nonzero C. `dout[15]` is the code sign, `dout[14:10]` is C ORed with 8, `dout[9:0]` is zero, and `dout[31:16]` is zero.
- R7: In decode mode, a code exponent of 0 gives an all-zero output (positive zero), even when the code's sign bit is set.
- R8: The nibble that decode uses is `din[4*pos+3 : 4*pos]`, for every `pos` from 0 to 7.
- R9: `out_valid` is `in_valid` delayed by one clock. An active-low reset (`rst_n`=0) clears `out_valid` and `dout` to zero at once.
- R10: A cycle with `in_valid` low leaves `dout` unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands below are valid this cycle |
| op | input | 1 | 0 = encode to code, 1 = decode from code |
| fmt | input | 1 | 0 = single precision, 1 = half precision |
| pos | input | 3 | Nibble index used by decode |
| din | input | 32 | Floating-point operand (encode) or packed code word (decode) |
| out_valid | output | 1 | Result on `dout` is new this cycle |
| dout | output | 32 | Code (encode) or floating-point pattern (decode), zero-extended |

## Verification
Rounding and saturation can act on the same operand: an exponent difference of 6 with the top mantissa bit set rounds up to exactly 7, and a difference of 7 with that bit set would reach 8 and clamps back to 7. Vectors placed on both sides of this point check that the clamp fires only where it should. The exact-threshold exponent combined with a set rounding bit is another such meeting point, and it must give 1, not 2. The vector table is streamed back to back, so encode and decode, and the two formats, alternate from one cycle to the next. Each result is compared against a value the bench computes by hand from the requirements.

// File: rtl/fp4q_pkg.sv
package fp4q_pkg;

   typedef enum logic {
      OP_ENCODE = 1'b0,
      OP_DECODE = 1'b1
   } fp4q_op_e;

   typedef enum logic {
      FMT_SINGLE = 1'b0,
      FMT_HALF   = 1'b1
   } fp4q_fmt_e;

endpackage

// File: rtl/fp4q_encode.sv
// Threshold mapper: floating exponent -> signed 4-bit minifloat code.
module fp4q_encode #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned THRESH = 120,
   parameter int unsigned CEXP_W = 3
) (
   input  logic              sign_i,
   input  logic [EXP_W-1:0]  exp_i,
   input  logic              rnd_i,
   output logic [CEXP_W:0]   code_o
);

   localparam logic [EXP_W:0] THR_V = (EXP_W+1)'(THRESH);
   localparam logic [EXP_W:0] MAX_V = (EXP_W+1)'((1 << CEXP_W) - 1);

   if (THRESH >= (1 << EXP_W)) begin : g_bad_thresh
      $error("fp4q_encode: THRESH does not fit the exponent field");
   end
   if (CEXP_W >= EXP_W) begin : g_bad_cexp
      $error("fp4q_encode: code exponent must be narrower than input exponent");
   end

   logic [EXP_W:0]    wide_exp;
   logic [EXP_W:0]    span;
   logic [CEXP_W-1:0] cexp;

   always_comb begin
      wide_exp = {1'b0, exp_i};
      span     = wide_exp - THR_V + {{EXP_W{1'b0}}, rnd_i};
      if (wide_exp > THR_V) begin
         cexp = (span > MAX_V) ? MAX_V[CEXP_W-1:0] : span[CEXP_W-1:0];
      end else if (wide_exp == THR_V) begin
         cexp = CEXP_W'(1);
      end else begin
         cexp = '0;
      end
      code_o = {sign_i, cexp};
   end

   // Exponents far enough above the threshold must land on the top code.
   always_comb begin
      if (wide_exp >= THR_V + MAX_V) begin
         assert_sat_top_R3: assert (code_o[CEXP_W-1:0] == MAX_V[CEXP_W-1:0])
            else $error("saturation missed");
      end
   end

endmodule

// File: rtl/fp4q_decode.sv
// Rebuild a floating-point pattern from a signed 4-bit minifloat code.
module fp4q_decode #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned MAN_W  = 23,
   parameter int unsigned THRESH = 120,
   parameter int unsigned CEXP_W = 3
) (
   input  logic [CEXP_W:0]          code_i,
   output logic [EXP_W+MAN_W:0]     flt_o
);

   localparam logic [EXP_W-1:0] BASE_V = EXP_W'(THRESH);

   if ((THRESH & ((1 << CEXP_W) - 1)) != 0) begin : g_bad_base
      $error("fp4q_decode: THRESH low bits must be clear so OR equals add");
   end
   if (MAN_W < 1) begin : g_bad_man
      $error("fp4q_decode: mantissa width must be at least one");
   end

   logic [CEXP_W-1:0] cexp;
   logic [EXP_W-1:0]  exp_f;

   always_comb begin
      cexp  = code_i[CEXP_W-1:0];
      exp_f = BASE_V | EXP_W'(cexp);
      if (cexp == '0) begin
         flt_o = '0;
      end else begin
         flt_o = {code_i[CEXP_W], exp_f, {MAN_W{1'b0}}};
      end
   end

endmodule

// File: rtl/fp4q_nib_sel.sv
// Picks one lane of a packed word by index.
module fp4q_nib_sel #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned NIB_W  = 4
) (
   input  logic [WORD_W-1:0]                    word_i,
   input  logic [$clog2(WORD_W/NIB_W)-1:0]      pos_i,
   output logic [NIB_W-1:0]                     nib_o
);

   localparam int unsigned NIB_CNT = WORD_W / NIB_W;

   if (NIB_CNT * NIB_W != WORD_W) begin : g_bad_split
      $error("fp4q_nib_sel: word is not a whole number of lanes");
   end
   if ((1 << $clog2(NIB_CNT)) != NIB_CNT) begin : g_bad_count
      $error("fp4q_nib_sel: lane count must be a power of two");
   end

   logic [NIB_W-1:0] lanes [NIB_CNT];

   for (genvar g = 0; g < NIB_CNT; g++) begin : g_lane
      assign lanes[g] = word_i[g*NIB_W +: NIB_W];
   end

   assign nib_o = lanes[pos_i];

endmodule

// File: rtl/fp4q_top.sv
module fp4q_top #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned SP_EXP_W  = 8,
   parameter int unsigned SP_MAN_W  = 23,
   parameter int unsigned SP_THRESH = 120,
   parameter int unsigned HP_EXP_W  = 5,
   parameter int unsigned HP_MAN_W  = 10,
   parameter int unsigned HP_THRESH = 8,
   parameter int unsigned CEXP_W    = 3
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     in_valid,
   input  logic                                     op,
   input  logic                                     fmt,
   input  logic [$clog2(WORD_W/(CEXP_W+1))-1:0]     pos,
   input  logic [WORD_W-1:0]                        din,
   output logic                                     out_valid,
   output logic [WORD_W-1:0]                        dout
);
   import fp4q_pkg::*;

   localparam int unsigned CODE_W = CEXP_W + 1;
   localparam int unsigned SP_W   = 1 + SP_EXP_W + SP_MAN_W;
   localparam int unsigned HP_W   = 1 + HP_EXP_W + HP_MAN_W;

   if (SP_W != WORD_W) begin : g_bad_sp
      $error("fp4q_top: single format must fill the word");
   end
   if (HP_W > WORD_W) begin : g_bad_hp
      $error("fp4q_top: half format wider than the word");
   end

   logic [CODE_W-1:0] enc_sp, enc_hp, nib;
   logic [SP_W-1:0]   dec_sp;
   logic [HP_W-1:0]   dec_hp;
   logic [WORD_W-1:0] nxt;

   fp4q_encode #(.EXP_W(SP_EXP_W), .THRESH(SP_THRESH), .CEXP_W(CEXP_W)) u_enc_sp (
      .sign_i (din[SP_W-1]),
      .exp_i  (din[SP_MAN_W +: SP_EXP_W]),
      .rnd_i  (din[SP_MAN_W-1]),
      .code_o (enc_sp)
   );

   fp4q_encode #(.EXP_W(HP_EXP_W), .THRESH(HP_THRESH), .CEXP_W(CEXP_W)) u_enc_hp (
      .sign_i (din[HP_W-1]),
      .exp_i  (din[HP_MAN_W +: HP_EXP_W]),
      .rnd_i  (din[HP_MAN_W-1]),
      .code_o (enc_hp)
   );

   fp4q_nib_sel #(.WORD_W(WORD_W), .NIB_W(CODE_W)) u_nib (
      .word_i (din),
      .pos_i  (pos),
      .nib_o  (nib)
   );

   fp4q_decode #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W), .THRESH(SP_THRESH),
                 .CEXP_W(CEXP_W)) u_dec_sp (
      .code_i (nib),
      .flt_o  (dec_sp)
   );

   fp4q_decode #(.EXP_W(HP_EXP_W), .MAN_W(HP_MAN_W), .THRESH(HP_THRESH),
                 .CEXP_W(CEXP_W)) u_dec_hp (
      .code_i (nib),
      .flt_o  (dec_hp)
   );

   always_comb begin
      unique case ({op, fmt})
         {OP_ENCODE, FMT_SINGLE}: nxt = WORD_W'(enc_sp);
         {OP_ENCODE, FMT_HALF}:   nxt = WORD_W'(enc_hp);
         {OP_DECODE, FMT_SINGLE}: nxt = WORD_W'(dec_sp);
         default:                 nxt = WORD_W'(dec_hp);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dout      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dout <= nxt;
         end
      end
   end

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dout)));

   assert_enc_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_ENCODE) |=> (dout[WORD_W-1:CODE_W] == '0));

   assert_half_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_DECODE && fmt == FMT_HALF) |=> (dout[WORD_W-1:HP_W] == '0));

   assert_dec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_DECODE && nib[CEXP_W-1:0] == '0) |=> (dout == '0));

endmodule

// File: tb/tb_fp4q_top.sv
`timescale 1ns/1ps
module tb_fp4q_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op = 1'b0;
   logic        fmt = 1'b0;
   logic [2:0]  pos = '0;
   logic [31:0] din = '0;
   logic        out_valid;
   logic [31:0] dout;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   fp4q_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt(fmt),
      .pos(pos), .din(din), .out_valid(out_valid), .dout(dout)
   );

   // {req, op, fmt, pos, din, expected}
   localparam int NV = 33;
   localparam logic [72:0] VEC [NV] = '{
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3F000000, 32'h00000006},  // R1 e=126
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3F800000, 32'h00000007},  // R1 e=127
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3C800000, 32'h00000001},  // R1 e=121
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3CC00000, 32'h00000002},  // R1 e=121 round up
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3C400000, 32'h00000001},  // R1 e=120 with M set
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3BC00000, 32'h00000000},  // R1 e=119
      {4'd1, 1'b0, 1'b0, 3'd0, 32'h3CBFFFFF, 32'h00000001},  // R1 low mantissa ignored
      {4'd4, 1'b0, 1'b0, 3'd0, 32'hBD800000, 32'h0000000B},  // R4 sign in bit 3
      {4'd3, 1'b0, 1'b0, 3'd0, 32'h3F400000, 32'h00000007},  // R3 6+1 = 7 exactly
      {4'd3, 1'b0, 1'b0, 3'd0, 32'h3FC00000, 32'h00000007},  // R3 7+1 clamps
      {4'd3, 1'b0, 1'b0, 3'd0, 32'hFF800000, 32'h0000000F},  // R3 top exponent
      {4'd2, 1'b0, 1'b1, 3'd0, 32'h00002200, 32'h00000001},  // R2 e=8 with M set
      {4'd2, 1'b0, 1'b1, 3'd0, 32'h00002400, 32'h00000001},  // R2 e=9
      {4'd2, 1'b0, 1'b1, 3'd0, 32'h00002600, 32'h00000002},  // R2 e=9 round up
      {4'd2, 1'b0, 1'b1, 3'd0, 32'h00001C00, 32'h00000000},  // R2 e=7
      {4'd2, 1'b0, 1'b1, 3'd0, 32'h00003C00, 32'h00000007},  // R2 e=15
      {4'd3, 1'b0, 1'b1, 3'd0, 32'h00003A00, 32'h00000007},  // R3 half 6+1
      {4'd3, 1'b0, 1'b1, 3'd0, 32'h0000F800, 32'h0000000F},  // R3 half e=30 neg
      {4'd2, 1'b0, 1'b1, 3'd0, 32'hFFFF2400, 32'h00000001},  // R2 upper half ignored
      {4'd5, 1'b1, 1'b0, 3'd0, 32'h00000001, 32'h3C800000},  // R5 code 1
      {4'd5, 1'b1, 1'b0, 3'd0, 32'h00000007, 32'h3F800000},  // R5 code 7
      {4'd5, 1'b1, 1'b0, 3'd0, 32'h0000000B, 32'hBD800000},  // R5 negative
      {4'd7, 1'b1, 1'b0, 3'd0, 32'h00000008, 32'h00000000},  // R7 negative zero code
      {4'd7, 1'b1, 1'b0, 3'd0, 32'h00000000, 32'h00000000},  // R7 zero code
      {4'd8, 1'b1, 1'b0, 3'd7, 32'h5FFFFFFF, 32'h3E800000},  // R8 top lane
      {4'd8, 1'b1, 1'b0, 3'd3, 32'h0000E000, 32'hBF000000},  // R8 lane 3
      {4'd8, 1'b1, 1'b0, 3'd3, 32'hFFFF0FFF, 32'h00000000},  // R8 zero lane among ones
      {4'd8, 1'b1, 1'b0, 3'd2, 32'hFFFF0FFF, 32'hBF800000},  // R8 neighbour lane
      {4'd6, 1'b1, 1'b1, 3'd0, 32'h00000001, 32'h00002400},  // R6 code 1
      {4'd6, 1'b1, 1'b1, 3'd0, 32'h00000007, 32'h00003C00},  // R6 code 7
      {4'd6, 1'b1, 1'b1, 3'd0, 32'hFFFFFFFC, 32'h0000B000},  // R6 negative
      {4'd7, 1'b1, 1'b1, 3'd0, 32'h00000008, 32'h00000000},  // R7 half zero
      {4'd8, 1'b1, 1'b1, 3'd5, 32'h00A00000, 32'h0000A800}   // R8 half lane 5
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(int i);
      in_valid = 1'b1;
      op       = VEC[i][68];
      fmt      = VEC[i][67];
      pos      = VEC[i][66:64];
      din      = VEC[i][63:32];
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset out_valid", {31'b0, out_valid}, 32'h0);
      check("R9 reset dout", dout, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", {31'b0, out_valid}, 32'h0);

      // Back-to-back stream through the table.
      drive(0);
      for (int i = 1; i <= NV; i++) begin
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[i-1][72:69], i-1), dout, VEC[i-1][31:0]);
         check("R9 out_valid", {31'b0, out_valid}, 32'h1);
         if (i < NV) drive(i);
      end

      // R10: idle cycle with busy inputs leaves dout untouched.
      in_valid = 1'b0;
      op  = 1'b0;
      fmt = 1'b0;
      din = 32'h3F800000;
      @(negedge clk);
      check("R10 hold dout", dout, 32'h0000A800);
      check("R9 out_valid drops", {31'b0, out_valid}, 32'h0);

      // R9: reset in the middle of a stream.
      drive(1);
      @(negedge clk);
      check("R9 loaded before reset", dout, 32'h00000007);
      rst_n = 1'b0;
      #1;
      check("R9 async clear valid", {31'b0, out_valid}, 32'h0);
      check("R9 async clear dout", dout, 32'h0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(20);
      @(negedge clk);
      check("R5 after reset", dout, 32'h3F800000);
      in_valid = 1'b0;
      @(negedge clk);

      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

endmodule